// File: doc/BRIEF.md
# ADC scan-mode channel sequencer

This block runs an external analog-to-digital converter over a group of channels in scan mode. Software, a timer pulse or an external trigger pulse sets the start bit. While the start bit is 1, the block issues one convert request per channel and always begins at in-group index 0. It stores each returned sample in the result register that belongs to that index. When the last channel of the group is done, the block sets an end flag and goes back to index 0 without any new trigger. Scanning runs until software clears the start bit.

The converter is modelled as a request/done handshake. The block pulses `conv_req` for one cycle together with the channel number on `conv_ch`. Later the converter returns `conv_done` with the sample on `conv_data`. The channel set, the group and the channel count are taken in on the cycle the scan is triggered, and they stay fixed for the whole scan. To change them, software stops the scan and triggers it again. A sample that arrives after the stop is dropped.

Top module: `adc_scan_seq`

## Requirements
- R1: A one-cycle pulse on `sw_start`, `tmr_trig` or `ext_trig` while `scan_on` is 0 makes `scan_on` read 1 from the next cycle.
- R2: The first request of every scan comes in the cycle after the trigger, with in-group index 0 (`conv_ch[1:0]` = 0). The config inputs sampled in the trigger cycle apply to that scan.
- R3: When `conv_done` is sampled during a scan and `sw_stop` is not high in that cycle, the next request is pulsed in the very next cycle.
- R4: Each accepted sample is written to result register `res_flat[i*DW +: DW]`, where i is the in-group index of the channel just converted.
- R5: When the sample of the last channel in the group is accepted, `end_flag` reads 1 from the next cycle and the next request goes to in-group index 0.
- R6: `irq` equals `end_flag` AND `irq_en` in every cycle.
- R7: A pulse on `sw_stop` during a scan clears `scan_on` from the next cycle. After that, no request is pulsed. A `conv_done` that arrives while `scan_on` is 0 changes no result register.
- R8: A trigger after a stop starts the scan again at index 0, not at the index where it stopped.
- R9: `ch_cnt` sets how many channels the group has: 00 gives index 0 only, 01 gives 0..1, 10 gives 0..2 and 11 gives 0..3. `conv_ch` is the concatenation {set bit, group bit, index}.
- R10: `end_flag` stays at 1 until a cycle in which `flag_clr` is high. If the flag is set and cleared in the same cycle, the set wins.
- R11: While `scan_on` is 1, trigger pulses have no effect, and changes on `set_sel`, `grp_sel` or `ch_cnt` have no effect either. `conv_ch[3:2]` and the scan length stay as they were when the scan was triggered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sw_start | input | 1 | Software sets the start bit (pulse) |
| tmr_trig | input | 1 | Timer trigger (pulse) |
| ext_trig | input | 1 | External trigger (pulse) |
| sw_stop | input | 1 | Software clears the start bit (pulse) |
| set_sel | input | 1 | Channel set select |
| grp_sel | input | 1 | Channel group select |
| ch_cnt | input | 2 | Number of channels in the group minus one |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Software clears the end flag |
| conv_done | input | 1 | Converter has finished a conversion |
| conv_data | input | DW | Sample returned with `conv_done` |
| conv_req | output | 1 | One-cycle convert request |
| conv_ch | output | 4 | Absolute channel to convert |
| scan_on | output | 1 | Start bit |
| end_flag | output | 1 | Pass complete flag |
| irq | output | 1 | Interrupt request |
| res_flat | output | 4*DW | Result registers, index i at bits i*DW +: DW |

## Verification
A wrong channel index shows at the ports within one request: a wrong `conv_ch`, or the sample written to the wrong register, one cycle after `conv_done`. A bad wrap, or a scan length read from live inputs, gives a wrong channel or a missing `end_flag` before the end of the first pass. A start bit that does not clear, or an in-flight sample that is not dropped, shows as a request while idle or a changed register a few cycles after the stop. The reference model compares every output on every cycle, so each of these faults is reported in the cycle where it first appears.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  parameter int CNT_W = 2;
  parameter int NCH   = 1 << CNT_W;
  parameter int CH_W  = CNT_W + 2;

  typedef struct packed {
    logic             set_sel;
    logic             grp_sel;
    logic [CNT_W-1:0] cnt;
  } scan_cfg_t;
endpackage

// File: rtl/adc_scan_start.sv
module adc_scan_start
  import adc_scan_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sw_start,
  input  logic      tmr_trig,
  input  logic      ext_trig,
  input  logic      sw_stop,
  input  scan_cfg_t cfg_in,
  output logic      run,
  output logic      launch,
  output scan_cfg_t cfg_q
);
  logic      run_d;
  logic      any_trig;
  scan_cfg_t cfg_d;

  always_comb begin
    any_trig = sw_start | tmr_trig | ext_trig;
    launch   = ~run & any_trig;
    run_d    = run ? ~sw_stop : any_trig;
    cfg_d    = cfg_q;
    if (launch) cfg_d = cfg_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= 1'b0;
      cfg_q <= '0;
    end else begin
      run   <= run_d;
      cfg_q <= cfg_d;
    end
  end

  AST_RETRIGGER_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    run && !sw_stop |=> run && $stable(cfg_q)); // R11
  AST_TRIGGER_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    !run && (sw_start || tmr_trig || ext_trig) |=> run); // R1
endmodule

// File: rtl/adc_scan_walker.sv
module adc_scan_walker
  import adc_scan_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             launch,
  input  logic             sw_stop,
  input  logic             conv_done,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] idx,
  output logic             conv_req,
  output logic             accept,
  output logic             pass_end
);
  logic [CNT_W-1:0] idx_d;
  logic             req_d;
  logic             last;

  always_comb begin
    accept   = run & conv_done;
    last     = (idx == cnt);
    pass_end = accept & last;
    idx_d    = idx;
    if (launch)      idx_d = '0;
    else if (accept) idx_d = last ? '0 : idx + 1'b1;
    req_d    = launch | (accept & ~sw_stop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx      <= '0;
      conv_req <= 1'b0;
    end else begin
      idx      <= idx_d;
      conv_req <= req_d;
    end
  end

  AST_START_AT_CH0: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> conv_req && idx == '0); // R2
  AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    run && conv_done && !sw_stop |=> conv_req); // R3
  AST_NO_REQ_WHEN_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !conv_req); // R7
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    pass_end |=> idx == '0); // R5
endmodule

// File: rtl/adc_scan_results.sv
module adc_scan_results
  import adc_scan_pkg::*;
#(
  parameter int DW = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  output logic [NCH*DW-1:0] res_flat
);
  for (genvar i = 0; i < NCH; i++) begin : g_reg
    logic          en;
    logic [DW-1:0] q;
    logic [DW-1:0] d;

    always_comb begin
      en = wr_en && (wr_idx == CNT_W'(i));
      d  = en ? wr_data : q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end

    assign res_flat[i*DW +: DW] = q;
  end

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(res_flat)); // R7
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int DW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_start,
  input  logic              tmr_trig,
  input  logic              ext_trig,
  input  logic              sw_stop,
  input  logic              set_sel,
  input  logic              grp_sel,
  input  logic [CNT_W-1:0]  ch_cnt,
  input  logic              irq_en,
  input  logic              flag_clr,
  input  logic              conv_done,
  input  logic [DW-1:0]     conv_data,
  output logic              conv_req,
  output logic [CH_W-1:0]   conv_ch,
  output logic              scan_on,
  output logic              end_flag,
  output logic              irq,
  output logic [NCH*DW-1:0] res_flat
);
  logic             rst_meta;
  logic             rst_s;
  logic             launch;
  logic             accept;
  logic             pass_end;
  logic             flag_d;
  logic [CNT_W-1:0] idx;
  scan_cfg_t        cfg_in;
  scan_cfg_t        cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  assign cfg_in = '{set_sel: set_sel, grp_sel: grp_sel, cnt: ch_cnt};

  adc_scan_start u_start (
    .clk(clk), .rst_n(rst_s), .sw_start(sw_start), .tmr_trig(tmr_trig),
    .ext_trig(ext_trig), .sw_stop(sw_stop), .cfg_in(cfg_in),
    .run(scan_on), .launch(launch), .cfg_q(cfg_q)
  );

  adc_scan_walker u_walk (
    .clk(clk), .rst_n(rst_s), .run(scan_on), .launch(launch),
    .sw_stop(sw_stop), .conv_done(conv_done), .cnt(cfg_q.cnt),
    .idx(idx), .conv_req(conv_req), .accept(accept), .pass_end(pass_end)
  );

  adc_scan_results #(.DW(DW)) u_res (
    .clk(clk), .rst_n(rst_s), .run(scan_on), .wr_en(accept),
    .wr_idx(idx), .wr_data(conv_data), .res_flat(res_flat)
  );

  always_comb begin
    flag_d = end_flag;
    if (pass_end)      flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;
    conv_ch = {cfg_q.set_sel, cfg_q.grp_sel, idx};
    irq     = end_flag & irq_en;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) end_flag <= 1'b0;
    else        end_flag <= flag_d;
  end

  AST_FLAG_FROM_PASS: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(end_flag) |-> $past(conv_done) && $past(scan_on)); // R5
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_s)
    end_flag && !flag_clr |=> end_flag); // R10
endmodule

// File: tb/adc_scan_seq_tb_top.sv
`timescale 1ns/1ps
module adc_scan_seq_tb_top;
  localparam int DW = 10;
  localparam int NR = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_start = 0, tmr_trig = 0, ext_trig = 0, sw_stop = 0;
  logic set_sel = 0, grp_sel = 0, irq_en = 0, flag_clr = 0;
  logic [1:0] ch_cnt = 0;
  logic conv_done = 0;
  logic [DW-1:0] conv_data = 0;
  logic conv_req, scan_on, end_flag, irq;
  logic [3:0] conv_ch;
  logic [NR*DW-1:0] res_flat;

  int checks = 0, failures = 0, cycles = 0;

  always #2.5 clk = ~clk;

  adc_scan_seq #(.DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .sw_start(sw_start), .tmr_trig(tmr_trig),
    .ext_trig(ext_trig), .sw_stop(sw_stop), .set_sel(set_sel),
    .grp_sel(grp_sel), .ch_cnt(ch_cnt), .irq_en(irq_en),
    .flag_clr(flag_clr), .conv_done(conv_done), .conv_data(conv_data),
    .conv_req(conv_req), .conv_ch(conv_ch), .scan_on(scan_on),
    .end_flag(end_flag), .irq(irq), .res_flat(res_flat)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // reference model of the requirements
  int m_run, m_idx, m_req, m_flag, m_set, m_grp, m_cnt;
  int m_res[NR];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_idx = 0; m_req = 0; m_flag = 0;
      m_set = 0; m_grp = 0; m_cnt = 0;
      foreach (m_res[i]) m_res[i] = 0;
    end else begin
      int trig, acc, last, start;
      trig  = (sw_start || tmr_trig || ext_trig) ? 1 : 0;
      start = (m_run == 0 && trig == 1) ? 1 : 0;
      acc   = (m_run == 1 && conv_done) ? 1 : 0;
      last  = (m_idx == m_cnt) ? 1 : 0;
      if (acc == 1) m_res[m_idx] = int'(conv_data);
      if (acc == 1 && last == 1) m_flag = 1;
      else if (flag_clr) m_flag = 0;
      m_req = (start == 1 || (acc == 1 && !sw_stop)) ? 1 : 0;
      if (start == 1) begin
        m_idx = 0; m_set = int'(set_sel); m_grp = int'(grp_sel); m_cnt = int'(ch_cnt);
      end else if (acc == 1) m_idx = (last == 1) ? 0 : m_idx + 1;
      if (m_run == 1) m_run = sw_stop ? 0 : 1;
      else            m_run = trig;
    end
  end

  always @(negedge clk) begin
    cycles++;
    chk("R1 scan_on", int'(scan_on), m_run);
    chk("R3 conv_req", int'(conv_req), m_req);
    chk("R9 conv_ch", int'(conv_ch), m_set * 8 + m_grp * 4 + m_idx);
    chk("R5 end_flag", int'(end_flag), m_flag);
    chk("R6 irq", int'(irq), (m_flag == 1 && irq_en) ? 1 : 0);
    for (int i = 0; i < NR; i++)
      chk("R4 result", int'(res_flat[i*DW +: DW]), m_res[i]);
  end

  // converter model: variable latency, done sampled at a later edge
  int busy = 0, cd = 0, nconv = 0;
  always @(negedge clk) begin
    conv_done = 1'b0;
    if (busy == 1) begin
      cd--;
      if (cd == 0) begin
        conv_done = 1'b1;
        conv_data = DW'(nconv * 37 + int'(conv_ch) * 11 + 5);
        busy = 0;
      end
    end
    if (conv_req) begin
      busy = 1;
      cd = 2 + (nconv % 3);
      nconv++;
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_flag();
    for (int i = 0; i < 200 && !end_flag; i++) @(negedge clk);
  endtask

  initial begin
    int hold;
    int saved [NR];
    rst_n = 0;
    cyc(3);
    chk("R1 reset scan_on", int'(scan_on), 0);
    chk("R5 reset end_flag", int'(end_flag), 0);
    rst_n = 1;
    cyc(4);

    // software start, three channels, interrupt enabled
    ch_cnt = 2'b10; irq_en = 1;
    sw_start = 1; cyc(1); sw_start = 0;
    chk("R1 start after sw", int'(scan_on), 1);
    chk("R2 first channel", int'(conv_ch), 0);
    chk("R2 first request", int'(conv_req), 1);
    wait_flag();
    chk("R5 flag after pass", int'(end_flag), 1);
    chk("R6 irq raised", int'(irq), 1);
    chk("R5 wrap to index 0", int'(conv_ch[1:0]), 0);
    cyc(3);
    flag_clr = 1; cyc(1); flag_clr = 0;
    wait_flag();
    chk("R5 flag second pass", int'(end_flag), 1);
    irq_en = 0; cyc(1);
    chk("R6 irq masked", int'(irq), 0);

    // R11: retrigger and config change during scan
    ext_trig = 1; set_sel = 1; grp_sel = 1; ch_cnt = 2'b00; cyc(1);
    ext_trig = 0;
    cyc(30);
    chk("R11 set/group unchanged", int'(conv_ch[3:2]), 0);
    chk("R11 still running", int'(scan_on), 1);

    // R7: stop right after a request, in-flight sample discarded
    for (int i = 0; i < 40 && !conv_req; i++) cyc(1);
    sw_stop = 1; cyc(1); sw_stop = 0;
    for (int i = 0; i < NR; i++) saved[i] = int'(res_flat[i*DW +: DW]);
    chk("R7 halted", int'(scan_on), 0);
    cyc(12);
    chk("R7 no request idle", int'(conv_req), 0);
    for (int i = 0; i < NR; i++)
      chk("R7 register untouched", int'(res_flat[i*DW +: DW]), saved[i]);

    // R10: flag holds while idle, clear drops it
    hold = int'(end_flag);
    cyc(5);
    chk("R10 flag holds", int'(end_flag), hold);
    flag_clr = 1; cyc(1); flag_clr = 0;
    chk("R10 flag cleared", int'(end_flag), 0);

    // R8/R9: timer restart, one channel, set 1 group 1
    set_sel = 1; grp_sel = 1; ch_cnt = 2'b00;
    tmr_trig = 1; cyc(1); tmr_trig = 0;
    chk("R8 restart at index 0", int'(conv_ch), 12);
    wait_flag();
    chk("R9 one-channel pass", int'(end_flag), 1);
    flag_clr = 1; cyc(40); flag_clr = 0;
    sw_stop = 1; cyc(1); sw_stop = 0;
    cyc(12);

    // R9: external start, four channels, set 1 group 0, stop/start same cycle idle
    set_sel = 1; grp_sel = 0; ch_cnt = 2'b11; irq_en = 1;
    ext_trig = 1; sw_stop = 1; cyc(1); ext_trig = 0; sw_stop = 0;
    chk("R1 ext trigger start", int'(scan_on), 1);
    chk("R9 set bit in channel", int'(conv_ch), 8);
    wait_flag();
    cyc(1);
    flag_clr = 1; cyc(60); flag_clr = 0;
    wait_flag();
    chk("R9 four-channel pass", int'(end_flag), 1);
    sw_stop = 1; cyc(1); sw_stop = 0;
    cyc(12);
    chk("R7 final idle", int'(conv_req), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule